// File: doc/BRIEF.md
# Per-Port Jabber Cutoff Guard

This block guards one port of a multiport fast Ethernet repeater against a station that transmits without end. It samples the port's synchronised carrier-sense input once per local clock and counts how many cycles in a row carrier has been present. If that run goes past a fixed limit, the port is cut off. The block then drops both its receive-enable and its transmit-enable gating outputs, and it raises a jabber status flag. Other ports have their own copy of the block, so no other port is affected.

The cutoff has no timed end. It lasts for as long as carrier persists. The port is let back in on the first cycle in which carrier is absent and the separately decoded idle-line indication is present. A one-cycle event pulse marks each entry into the cutoff, so that management logic can count jabber occurrences. The default limit of 16375 cycles matches a 25 MHz nibble clock and a limit of about 655 µs. The limit is a parameter, so a simulation can use a small value.

Top module: `jab_port_guard`

## Requirements
- R1: While reset is asserted and on the first cycle after it, rx_en_o and tx_en_o are 1, jabber_o is 0 and jab_start_o is 0.
- R2: Carrier held high for exactly LIMIT_CYCLES consecutive sampled cycles and then dropped causes no cutoff.
- R3: When carrier is sampled high on LIMIT_CYCLES+1 consecutive clock edges, the outputs after that last edge show rx_en_o=0, tx_en_o=0 and jabber_o=1.
- R4: A single cycle with carrier low clears the run, so that separate bursts never add up to a cutoff.
- R5: A cut-off port stays cut off while carrier is high, whatever the idle input says. It also stays cut off while carrier is low and idle_i is 0. It is re-enabled after the first edge at which carrier is 0 and idle_i is 1.
- R6: jab_start_o is 1 for exactly the one cycle in which the cutoff is entered, and is 0 at all other times.
- R7: Carrier that keeps going far past the limit neither re-enables the port nor produces a second start pulse, because the run counter saturates.
- R8: After a re-enable, a new cutoff needs a fresh run of LIMIT_CYCLES+1 consecutive high cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local repeater clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| crs_i | input | 1 | Synchronised carrier sense of the port |
| idle_i | input | 1 | Synchronised idle-line indication of the port |
| rx_en_o | output | 1 | Receive-path enable for the port, 0 while cut off |
| tx_en_o | output | 1 | Transmit-path enable for the port, 0 while cut off |
| jabber_o | output | 1 | Jabber status, 1 while cut off |
| jab_start_o | output | 1 | One-cycle pulse on entry into the cutoff |

## Verification
Directed runs use carrier bursts of exactly the limit and of one cycle more. These two runs separate a correct threshold from an off-by-one error in either direction. Two sub-limit bursts split by one low cycle expose a counter that fails to clear.

In the cutoff state, the bench drives carrier low without idle, and then idle while carrier is high. These patterns show that re-enable depends on both conditions together. A run held far past the limit checks the saturation and the single start pulse.

Random bursts of varied lengths around the limit, with random idle gaps, are compared cycle by cycle against a reference model kept in the bench.

// File: rtl/jab_guard_pkg.sv
package jab_guard_pkg;
  typedef enum logic {
    ST_PASS = 1'b0,
    ST_CUT  = 1'b1
  } guard_state_e;

  function automatic int unsigned run_bits(input int unsigned limit);
    return $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/jab_run_counter.sv
module jab_run_counter #(
  parameter int unsigned LIMIT = 16375,
  localparam int unsigned W = jab_guard_pkg::run_bits(LIMIT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_i,
  output logic at_limit_o
);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  logic [W-1:0] run_q, run_d;
  logic         run_en;

  always_comb begin
    run_en = carrier_i ? (run_q != LIM_V) : (run_q != '0);
    run_d  = carrier_i ? run_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  assign at_limit_o = (run_q == LIM_V);

  // R4: one low sample empties the run
  a_r4_clear_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier_i |=> !at_limit_o && (run_q == '0));

  // R7: counter holds at the limit instead of wrapping
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (at_limit_o && carrier_i) |=> at_limit_o);

  // R7: never beyond the limit
  a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LIM_V);
endmodule

// File: rtl/jab_cut_fsm.sv
module jab_cut_fsm
  import jab_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_i,
  input  logic idle_i,
  input  logic at_limit_i,
  output logic cut_o,
  output logic entry_o
);
  guard_state_e state_q, state_d;
  logic         entry_q, entry_d;

  always_comb begin
    state_d = state_q;
    entry_d = 1'b0;
    unique case (state_q)
      ST_PASS: if (carrier_i && at_limit_i) begin
        state_d = ST_CUT;
        entry_d = 1'b1;
      end
      ST_CUT:  if (!carrier_i && idle_i) state_d = ST_PASS;
      default: state_d = ST_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PASS;
      entry_q <= 1'b0;
    end else begin
      state_q <= state_d;
      entry_q <= entry_d;
    end
  end

  assign cut_o   = (state_q == ST_CUT);
  assign entry_o = entry_q;

  // R3: cutoff only after an over-limit run
  a_r3_entry_needs_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cut_o) |-> $past(carrier_i) && $past(at_limit_i));

  // R5: leaving the cutoff needs carrier low and idle seen together
  a_r5_exit_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cut_o) |-> $past(!carrier_i) && $past(idle_i));

  // R5: carrier keeps the port cut off
  a_r5_hold_on_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_o && carrier_i) |=> cut_o);

  // R6: start pulse lasts one cycle and coincides with a fresh cutoff
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |=> !entry_o);

  a_r6_pulse_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> cut_o && $past(!cut_o));
endmodule

// File: rtl/jab_port_guard.sv
module jab_port_guard #(
  parameter int unsigned LIMIT_CYCLES = 16375
) (
  input  logic clk,
  input  logic rst_n,
  input  logic crs_i,
  input  logic idle_i,
  output logic rx_en_o,
  output logic tx_en_o,
  output logic jabber_o,
  output logic jab_start_o
);
  logic at_limit;
  logic cut;

  jab_run_counter #(.LIMIT(LIMIT_CYCLES)) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrier_i  (crs_i),
    .at_limit_o (at_limit)
  );

  jab_cut_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrier_i  (crs_i),
    .idle_i     (idle_i),
    .at_limit_i (at_limit),
    .cut_o      (cut),
    .entry_o    (jab_start_o)
  );

  assign rx_en_o  = !cut;
  assign tx_en_o  = !cut;
  assign jabber_o = cut;

  // R1: quiet outputs in reset
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |-> rx_en_o && tx_en_o && !jabber_o && !jab_start_o);
endmodule

// File: tb/jab_port_guard_test.sv
`timescale 1ns/1ps
module jab_port_guard_test;
  localparam int unsigned L = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic crs, idle;
  logic rx_en, tx_en, jab, start;
  int checks = 0;
  int errors = 0;

  int m_cnt;
  bit m_cut, m_evt;

  always #2 clk = ~clk;

  jab_port_guard #(.LIMIT_CYCLES(L)) uut (
    .clk(clk), .rst_n(rst_n), .crs_i(crs), .idle_i(idle),
    .rx_en_o(rx_en), .tx_en_o(tx_en), .jabber_o(jab), .jab_start_o(start)
  );

  function automatic bit ref_evt(bit cut, int cnt, bit c);
    return !cut && c && (cnt > int'(L) - 1);
  endfunction

  function automatic bit ref_cut(bit cut, bit evt, bit c, bit i);
    if (cut) return !(!c && i);
    return evt;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (rx_en !== !m_cut || tx_en !== !m_cut || jab !== m_cut || start !== m_evt) begin
      errors++;
      $display("FAIL %s: rx=%b tx=%b jab=%b start=%b expected rx=%b tx=%b jab=%b start=%b",
               tag, rx_en, tx_en, jab, start, !m_cut, !m_cut, m_cut, m_evt);
    end
  endtask

  task automatic step(bit c, bit i, string tag);
    bit e;
    crs  = c;
    idle = i;
    @(posedge clk);
    e     = ref_evt(m_cut, m_cnt, c);
    m_cut = ref_cut(m_cut, e, c, i);
    m_evt = e;
    m_cnt = c ? ((m_cnt >= int'(L)) ? int'(L) : m_cnt + 1) : 0;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic burst(int n, string tag);
    for (int k = 0; k < n; k++) step(1'b1, 1'b0, tag);
  endtask

  initial begin
    for (int w = 0; w < 150000; w++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; crs = 1'b0; idle = 1'b1;
    m_cnt = 0; m_cut = 1'b0; m_evt = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1");
    // reset with carrier active must still show the enabled state
    crs = 1'b1; @(negedge clk); compare("R1");
    rst_n = 1'b1;
    step(1'b0, 1'b1, "R1");

    // R2: exactly the limit
    burst(L, "R2");
    step(1'b0, 1'b1, "R2");

    // R4: two sub-limit runs with one low cycle between
    burst(L - 2, "R4");
    step(1'b0, 1'b0, "R4");
    burst(L - 2, "R4");
    step(1'b0, 1'b1, "R4");

    // R3 and R6: one cycle over the limit
    burst(L, "R3");
    step(1'b1, 1'b0, "R3");
    step(1'b1, 1'b0, "R6");

    // R7: very long jabber
    burst(5 * L, "R7");

    // R5: low carrier without idle, then idle while carrier high
    step(1'b0, 1'b0, "R5");
    step(1'b0, 1'b0, "R5");
    step(1'b1, 1'b1, "R5");
    step(1'b0, 1'b1, "R5");
    step(1'b0, 1'b1, "R5");

    // R8: fresh run needed after re-enable
    burst(L, "R8");
    step(1'b1, 1'b0, "R8");
    step(1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, "R8");

    // random bursts around the limit
    for (int b = 0; b < 300; b++) begin
      int len = $urandom_range(1, L + 6);
      int gap = $urandom_range(1, 5);
      for (int k = 0; k < len; k++) step(1'b1, 1'($urandom_range(0, 1)), "R3");
      for (int k = 0; k < gap; k++) step(1'b0, 1'($urandom_range(0, 1)), "R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule